// File: doc/BRIEF.md
# Split-Width Sequential Adder

This block adds two 32-bit integers using only one 16-bit adder. It works through a fixed series of steps, the way a short microcode routine would. After a start strobe it captures both operands. It adds the low halves and keeps that carry. It then adds the high halves. In a separate pass it adds the kept carry to that partial high result. Finally it delivers the full sum, a one-cycle done pulse and four condition flags.

Each step takes one clock, so a result always arrives a fixed seven cycles after an accepted start. A start strobe that arrives while a sequence is running is ignored. The sum and the flags keep their values until the next sequence finishes. The half width is a parameter, and the full width is twice that.

Top module: `wide_add_seq`

## Requirements
- R1: After a synchronous active-high reset, sum, done and all four flags read 0.
- R2: done is high for exactly one cycle, on the seventh rising edge after the edge that accepted start.
- R3: On done, sum equals (A + B) modulo 2^32, using the operands captured at the accepting edge.
- R4: On done, carryFlag equals the unsigned carry out of the full 32-bit addition.
- R5: On done, overflowFlag is 1 exactly when both operands have the same bit 31 and the sum's bit 31 differs from it.
- R6: On done, zeroFlag is 1 exactly when all 32 bits of sum are 0.
- R7: On done, negFlag equals bit 31 of sum.
- R8: start is ignored from the accepting edge up to and including the edge that raises done; start is accepted again on the next edge.
- R9: sum and the flags change only on the edge that raises done, and hold their values otherwise.
- R10: Changes to addendA and addendB after the accepting edge do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an addition when idle |
| addendA | input | 32 | First operand |
| addendB | input | 32 | Second operand |
| sum | output | 32 | Registered 32-bit result |
| done | output | 1 | One-cycle pulse when the result is updated |
| carryFlag | output | 1 | Unsigned carry out |
| overflowFlag | output | 1 | Signed overflow |
| zeroFlag | output | 1 | Full result is zero |
| negFlag | output | 1 | Result sign bit |

## Verification
The bench builds the block with the default half width of 16. Operands can then be chosen so that a carry appears at each of the three points where it can arise. The first is the low pass alone, where 0x0000FFFF + 1 stops at the half boundary. The second is the first high pass, as in 0xFFFF0000 + 0x00010000. The third is only the second high pass, where a high partial of 0xFFFF absorbs the kept low carry. The bench also drives signed overflow in both directions, an all-zero wrap, and start strobes during a run and held high without a break.

// File: rtl/wide_add_seq_pkg.sv
package wide_add_seq_pkg;

  typedef enum logic [2:0] {
    stIdle,
    stLoadLo,
    stAddLo,
    stLoadHi,
    stAddHi,
    stCopyHi,
    stAddCy,
    stFlags
  } seqState_t;

  // One strobe per micro step; at most one is high in any cycle.
  typedef struct packed {
    logic latchOps;
    logic loadLo;
    logic addLo;
    logic loadHi;
    logic addHi;
    logic copyHi;
    logic addCy;
    logic finish;
  } seqStrobes_t;

endpackage

// File: rtl/wide_add_seq_ctrl.sv
module wide_add_seq_ctrl
  import wide_add_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output seqStrobes_t strobes
);

  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      stIdle:   if (start) stateD = stLoadLo;
      stLoadLo: stateD = stAddLo;
      stAddLo:  stateD = stLoadHi;
      stLoadHi: stateD = stAddHi;
      stAddHi:  stateD = stCopyHi;
      stCopyHi: stateD = stAddCy;
      stAddCy:  stateD = stFlags;
      stFlags:  stateD = stIdle;
      default:  stateD = stIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= stIdle;
    else     stateQ <= stateD;
  end

  always_comb begin
    strobes          = '0;
    strobes.latchOps = (stateQ == stIdle) && start;
    strobes.loadLo   = (stateQ == stLoadLo);
    strobes.addLo    = (stateQ == stAddLo);
    strobes.loadHi   = (stateQ == stLoadHi);
    strobes.addHi    = (stateQ == stAddHi);
    strobes.copyHi   = (stateQ == stCopyHi);
    strobes.addCy    = (stateQ == stAddCy);
    strobes.finish   = (stateQ == stFlags);
  end

endmodule

// File: rtl/wide_add_seq_dp.sv
module wide_add_seq_dp
  import wide_add_seq_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strobes,
  input  logic [FULL_W-1:0] addendA,
  input  logic [FULL_W-1:0] addendB,
  output logic [FULL_W-1:0] sum,
  output logic              done,
  output logic              carryFlag,
  output logic              overflowFlag,
  output logic              zeroFlag,
  output logic              negFlag
);

  logic [FULL_W-1:0] opA, opB;
  logic [HALF_W-1:0] scr0, scr1, scr2, scr3;   // high result, low result, adder inputs
  logic              keptCarry, hiCarry1, hiCarry2;

  // The one shared half-width adder.
  logic [HALF_W-1:0] adderY, adderRes;
  logic              adderCout;

  always_comb begin
    adderY = strobes.addCy ? {{(HALF_W-1){1'b0}}, keptCarry} : scr3;
    {adderCout, adderRes} = {1'b0, scr2} + {1'b0, adderY};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opA       <= '0;
      opB       <= '0;
      scr0      <= '0;
      scr1      <= '0;
      scr2      <= '0;
      scr3      <= '0;
      keptCarry <= 1'b0;
      hiCarry1  <= 1'b0;
      hiCarry2  <= 1'b0;
    end else begin
      if (strobes.latchOps) begin
        opA <= addendA;
        opB <= addendB;
      end
      if (strobes.loadLo) begin
        scr2 <= opA[HALF_W-1:0];
        scr3 <= opB[HALF_W-1:0];
      end
      if (strobes.addLo) begin
        scr1      <= adderRes;
        keptCarry <= adderCout;
      end
      if (strobes.loadHi) begin
        scr2 <= opA[FULL_W-1:HALF_W];
        scr3 <= opB[FULL_W-1:HALF_W];
      end
      if (strobes.addHi) begin
        scr0     <= adderRes;
        hiCarry1 <= adderCout;
      end
      if (strobes.copyHi) scr2 <= scr0;
      if (strobes.addCy) begin
        scr0     <= adderRes;
        hiCarry2 <= adderCout;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum          <= '0;
      done         <= 1'b0;
      carryFlag    <= 1'b0;
      overflowFlag <= 1'b0;
      zeroFlag     <= 1'b0;
      negFlag      <= 1'b0;
    end else begin
      done <= strobes.finish;
      if (strobes.finish) begin
        sum          <= {scr0, scr1};
        carryFlag    <= hiCarry1 | hiCarry2;
        overflowFlag <= (opA[FULL_W-1] == opB[FULL_W-1]) && (scr0[HALF_W-1] != opA[FULL_W-1]);
        zeroFlag     <= ({scr0, scr1} == '0);
        negFlag      <= scr0[HALF_W-1];
      end
    end
  end

endmodule

// File: rtl/wide_add_seq.sv
module wide_add_seq
  import wide_add_seq_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FULL_W-1:0] addendA,
  input  logic [FULL_W-1:0] addendB,
  output logic [FULL_W-1:0] sum,
  output logic              done,
  output logic              carryFlag,
  output logic              overflowFlag,
  output logic              zeroFlag,
  output logic              negFlag
);

  seqStrobes_t strobes;

  wide_add_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .strobes (strobes)
  );

  wide_add_seq_dp #(.HALF_W(HALF_W)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .addendA      (addendA),
    .addendB      (addendB),
    .sum          (sum),
    .done         (done),
    .carryFlag    (carryFlag),
    .overflowFlag (overflowFlag),
    .zeroFlag     (zeroFlag),
    .negFlag      (negFlag)
  );

endmodule

// File: rtl/wide_add_seq_checker.sv
module wide_add_seq_checker #(
  parameter int HALF_W = 16,
  localparam int FULL_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [FULL_W-1:0] addendA,
  input logic [FULL_W-1:0] addendB,
  input logic [FULL_W-1:0] sum,
  input logic              done,
  input logic              carryFlag,
  input logic              overflowFlag,
  input logic              zeroFlag,
  input logic              negFlag
);

  logic [2:0]        runCnt;
  logic [FULL_W-1:0] heldA, heldB;
  logic [FULL_W:0]   wideSum;

  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt <= '0;
      heldA  <= '0;
      heldB  <= '0;
    end else if (runCnt == 0) begin
      if (start) begin
        runCnt <= 3'd1;
        heldA  <= addendA;
        heldB  <= addendB;
      end
    end else begin
      runCnt <= (runCnt == 3'd7) ? 3'd0 : runCnt + 3'd1;
    end
  end

  assign wideSum = {1'b0, heldA} + {1'b0, heldB};

  assert_done_time_R2: assert property (@(posedge clk) disable iff (rst)
    (runCnt == 3'd7) |=> done);
  assert_done_only_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(runCnt == 3'd7));
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_sum_value_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (sum == wideSum[FULL_W-1:0]));
  assert_carry_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (carryFlag == wideSum[FULL_W]));
  assert_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (overflowFlag == ((heldA[FULL_W-1] == heldB[FULL_W-1]) && (sum[FULL_W-1] != heldA[FULL_W-1]))));
  assert_zero_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (zeroFlag == (sum == '0)));
  assert_negative_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (negFlag == sum[FULL_W-1]));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(sum) && $stable(carryFlag) && $stable(overflowFlag) && $stable(zeroFlag) && $stable(negFlag)));

endmodule

bind wide_add_seq wide_add_seq_checker #(.HALF_W(HALF_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .addendA      (addendA),
  .addendB      (addendB),
  .sum          (sum),
  .done         (done),
  .carryFlag    (carryFlag),
  .overflowFlag (overflowFlag),
  .zeroFlag     (zeroFlag),
  .negFlag      (negFlag)
);

// File: tb/tb_wide_add_seq.sv
`timescale 1ns/1ps
module tb_wide_add_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] addendA = '0, addendB = '0;
  logic [31:0] sum;
  logic        done, carryFlag, overflowFlag, zeroFlag, negFlag;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wide_add_seq dut (
    .clk(clk), .rst(rst), .start(start), .addendA(addendA), .addendB(addendB),
    .sum(sum), .done(done), .carryFlag(carryFlag), .overflowFlag(overflowFlag),
    .zeroFlag(zeroFlag), .negFlag(negFlag)
  );

  // Behavioural reference: counts cycles of a run and computes results arithmetically.
  int          refCnt = 0;
  logic [31:0] refA = '0, refB = '0;
  logic [31:0] expSum = '0;
  logic        expDone = 0, expCarry = 0, expOvf = 0, expZero = 0, expNeg = 0;

  always @(posedge clk) begin
    longint unsigned full;
    expDone <= 1'b0;
    if (rst) begin
      refCnt <= 0; expSum <= '0; expCarry <= 0; expOvf <= 0; expZero <= 0; expNeg <= 0;
    end else if (refCnt == 0) begin
      if (start) begin refCnt <= 1; refA <= addendA; refB <= addendB; end
    end else if (refCnt == 7) begin
      full = longint'(refA) + longint'(refB);
      expSum   <= full[31:0];
      expCarry <= full[32];
      expOvf   <= (refA[31] == refB[31]) && (full[31] != refA[31]);
      expZero  <= (full[31:0] == 32'd0);
      expNeg   <= full[31];
      expDone  <= 1'b1;
      refCnt   <= 0;
    end else begin
      refCnt <= refCnt + 1;
    end
  end

  task automatic check1(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst && !finished) begin
      check1("R2 done", {31'd0, done}, {31'd0, expDone});
      check1("R3,R8,R9,R10 sum", sum, expSum);
      check1("R4 carryFlag", {31'd0, carryFlag}, {31'd0, expCarry});
      check1("R5 overflowFlag", {31'd0, overflowFlag}, {31'd0, expOvf});
      check1("R6 zeroFlag", {31'd0, zeroFlag}, {31'd0, expZero});
      check1("R7 negFlag", {31'd0, negFlag}, {31'd0, expNeg});
    end
  end

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // One run: stray start strobes while busy (R8) and operand changes after capture (R10).
  task automatic runAdd(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    addendA = a; addendB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; addendA = ~a; addendB = b ^ 32'h5A5A_A5A5;
    @(negedge clk);
    start = 1'b1; addendA = 32'h1234_5678;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check1("R1 sum after reset", sum, 32'd0);
    check1("R1 flags after reset", {27'd0, done, carryFlag, overflowFlag, zeroFlag, negFlag}, 32'd0);

    runAdd(32'h0000_0000, 32'h0000_0000);   // R6 zero
    runAdd(32'hFFFF_FFFF, 32'h0000_0001);   // R4 carry with zero wrap
    runAdd(32'h7FFF_FFFF, 32'h0000_0001);   // R5 positive overflow
    runAdd(32'h8000_0000, 32'h8000_0000);   // R5 negative overflow, R4 carry
    runAdd(32'h0000_FFFF, 32'h0000_0001);   // low-half carry into high
    runAdd(32'hFFFF_0000, 32'h0001_0000);   // carry from first high pass
    runAdd(32'hFFFF_8000, 32'h0000_8000);   // carry from second high pass only
    runAdd(32'h8000_0000, 32'h0000_0001);   // R7 negative, no overflow
    seed = 32'hACE1_2468;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] x;
      seed = nextRand(seed); x = seed;
      seed = nextRand(seed);
      runAdd(x, seed);
    end
    // R8: start held high without a break; back-to-back runs
    @(negedge clk);
    addendA = 32'h0001_FFFF; addendB = 32'h0000_0001; start = 1'b1;
    repeat (24) @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

endmodule